// File: doc/BRIEF.md
# Scatter-Gather Memory-to-Stream Descriptor Walker

This engine moves buffers from memory onto a 32-bit output data stream by following a chain of descriptors held in memory. A start trigger arrives when software writes the tail pointer. The engine then loads the descriptor at the current pointer and checks whether it is already marked complete. It sends the descriptor's application words on a separate control stream when the descriptor opens a frame. Next it streams the referenced buffer, writes the status word back with the completed flag set, and moves on along the next pointer. It stops after the descriptor that sits at the tail address.

The register block around the engine supplies the run and idle state, the current pointer and the tail pointer. The engine returns the updated current pointer together with single-cycle pulses that report a halt, the end of a walk (idle) and a finished frame (completion). The interrupt coalescing logic counts the completion pulses. Memory is reached through a simple read port, where a request handshake is followed later by one response word, and through a write port used only for status writeback.

Top module: `sgw_walker`

## Requirements
- R1: A walk starts on a `tail_wr_i` pulse only while `run_i` is 1 and `idle_i` is 0. A trigger under any other condition produces no memory request and no output.
- R2: Each descriptor is read as 32-bit little-endian words starting at the current pointer. The next pointer is at byte offset 0, the buffer address at offset 8, the control word at offset 24, the status word at offset 28 and the five application words at offsets 32 to 48. The upper halves of the 64-bit fields and the reserved words at offsets 16 and 20 are ignored.
- R3: If bit 31 of a fetched status word is 1, the engine pulses `halted_o` and stops. It sends no stream beat, does no writeback, gives no `cur_upd_o` and gives no `idle_set_o` for that descriptor.
- R4: When control bit 27 (start of frame) is 1, the five application words go out on the control stream in ascending address order, with `ctl_last_o` on the fifth. This happens before any data beat of that descriptor.
- R5: The buffer length is control bits [22:0] in bytes. The buffer goes out as ceil(len/4) data beats read from ascending word addresses starting at the buffer address, which must be word-aligned. Byte k of a beat is on bits [8k+7:8k]. A length of 0 gives no beat.
- R6: `dat_keep_o` is 4'hF on every beat except the final beat of a descriptor whose length is not a multiple of 4. On that beat only the low (len mod 4) bits are set.
- R7: `dat_last_o` is 1 only on the final beat of a descriptor whose control bit 26 (end of frame) is 1.
- R8: While a data beat is stalled (`dat_valid_o` is 1 and `dat_ready_i` is 0), the beat's data, keep and last hold stable, and no memory read request is issued.
- R9: After a descriptor's data, the value 32'h8000_0000 is written to the descriptor's address plus 28.
- R10: Each processed descriptor with end of frame set gives exactly one `cmpl_o` pulse. Descriptors without it give none.
- R11: After writeback, `cur_ptr_o` takes the descriptor's next pointer and `cur_upd_o` pulses. If the processed descriptor's address equals the tail pointer, `idle_set_o` pulses and the walk ends. Otherwise the next descriptor is fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Run state from the register block |
| idle_i | input | 1 | Idle state from the register block |
| tail_wr_i | input | 1 | Pulse: tail pointer was written |
| cur_ptr_i | input | ADDR_W | Current descriptor pointer |
| tail_ptr_i | input | ADDR_W | Tail descriptor pointer |
| cur_ptr_o | output | ADDR_W | Updated current pointer |
| cur_upd_o | output | 1 | Pulse: cur_ptr_o updated |
| halted_o | output | 1 | Pulse: completed descriptor met |
| idle_set_o | output | 1 | Pulse: tail reached |
| cmpl_o | output | 1 | Pulse: end-of-frame descriptor done |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_ready_i | input | 1 | Read request accepted |
| rd_addr_o | output | ADDR_W | Read byte address |
| rd_rsp_valid_i | input | 1 | Read response valid |
| rd_rsp_data_i | input | 32 | Read response word |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Write request accepted |
| wr_addr_o | output | ADDR_W | Write byte address |
| wr_data_o | output | 32 | Write word |
| ctl_valid_o | output | 1 | Control stream valid |
| ctl_ready_i | input | 1 | Control stream ready |
| ctl_data_o | output | 32 | Control stream word |
| ctl_last_o | output | 1 | Last application word |
| dat_valid_o | output | 1 | Data stream valid |
| dat_ready_i | input | 1 | Data stream ready |
| dat_data_o | output | 32 | Data stream word |
| dat_keep_o | output | 4 | Valid byte mask |
| dat_last_o | output | 1 | End of frame beat |

## Verification
The bench uses the default 32-bit addresses and 23-bit length field. It sweeps every buffer length from 0 to 12 bytes against all four combinations of the start and end flags. This covers every remainder of the keep mask, the empty buffer and both last/no-last cases in one small grid. A three-descriptor chain checks pointer following, tail detection and a single completion. Running the same chain a second time lands on a descriptor that the first walk marked complete, which brings the halt path within reach. Ready toggles pseudo-randomly throughout, so stalls hit every beat position.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int WORD_W     = 32;
  localparam int BYTES      = WORD_W / 8;
  localparam int DESC_WORDS = 8;
  localparam int APP_OFS    = 32;
  localparam int WB_OFS     = 28;
  localparam int NEXT_IDX   = 0;
  localparam int BUF_IDX    = 2;
  localparam int CTRL_IDX   = 6;
  localparam int STAT_IDX   = 7;
  localparam int SOF_BIT    = 27;
  localparam int EOF_BIT    = 26;
  localparam int DONE_BIT   = 31;

  typedef enum logic [1:0] {PH_DESC, PH_APP, PH_BUF} rd_phase_e;

  typedef enum logic [3:0] {
    S_IDLE, S_DRD, S_DWT, S_CHK, S_ARD, S_AWT, S_AOUT,
    S_BRD, S_BWT, S_BOUT, S_WB, S_ADV
  } walk_state_e;
endpackage

// File: rtl/sgw_addr_gen.sv
module sgw_addr_gen
  import sgw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  rd_phase_e         phase_i,
  input  logic [ADDR_W-1:0] desc_i,
  input  logic [ADDR_W-1:0] buf_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] word_ofs;
  assign word_ofs = ADDR_W'({idx_i, 2'b00});

  always_comb begin
    unique case (phase_i)
      PH_DESC: addr_o = desc_i + word_ofs;
      PH_APP:  addr_o = desc_i + ADDR_W'(APP_OFS) + word_ofs;
      default: addr_o = buf_i;
    endcase
  end
endmodule

// File: rtl/sgw_beat_fmt.sv
module sgw_beat_fmt
  import sgw_pkg::*;
#(
  parameter int LEN_W = 23
) (
  input  logic [LEN_W-1:0] rem_i,
  input  logic             eof_i,
  output logic [BYTES-1:0] keep_o,
  output logic             fin_o,
  output logic             last_o
);
  for (genvar b = 0; b < BYTES; b++) begin : g_keep
    assign keep_o[b] = rem_i > LEN_W'(b);
  end
  assign fin_o  = rem_i <= LEN_W'(BYTES);
  assign last_o = fin_o & eof_i;
endmodule

// File: rtl/sgw_walker.sv
module sgw_walker
  import sgw_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 23,
  parameter int APP_WORDS = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              idle_i,
  input  logic              tail_wr_i,
  input  logic [ADDR_W-1:0] cur_ptr_i,
  input  logic [ADDR_W-1:0] tail_ptr_i,
  output logic [ADDR_W-1:0] cur_ptr_o,
  output logic              cur_upd_o,
  output logic              halted_o,
  output logic              idle_set_o,
  output logic              cmpl_o,
  output logic              rd_req_valid_o,
  input  logic              rd_req_ready_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_rsp_valid_i,
  input  logic [31:0]       rd_rsp_data_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [31:0]       wr_data_o,
  output logic              ctl_valid_o,
  input  logic              ctl_ready_i,
  output logic [31:0]       ctl_data_o,
  output logic              ctl_last_o,
  output logic              dat_valid_o,
  input  logic              dat_ready_i,
  output logic [31:0]       dat_data_o,
  output logic [3:0]        dat_keep_o,
  output logic              dat_last_o
);
  localparam int MAXW  = (DESC_WORDS > APP_WORDS) ? DESC_WORDS : APP_WORDS;
  localparam int IDX_W = $clog2(MAXW) + 1;

  walk_state_e       st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] cur_q, tail_q, nxt_q, baddr_q, cur_o_q;
  logic [LEN_W-1:0]  len_q, rem_q;
  logic              sof_q, eof_q, done_q;
  logic [31:0]       hold_q;
  logic              halt_q, idle_q, cmpl_q, upd_q;
  rd_phase_e         phase;
  logic [BYTES-1:0]  keep;
  logic              fin, last;
  logic              start;

  assign start = tail_wr_i & run_i & ~idle_i;

  always_comb begin
    unique case (st_q)
      S_ARD:   phase = PH_APP;
      S_BRD:   phase = PH_BUF;
      default: phase = PH_DESC;
    endcase
  end

  sgw_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
    .phase_i(phase), .desc_i(cur_q), .buf_i(baddr_q), .idx_i(idx_q), .addr_o(rd_addr_o)
  );

  sgw_beat_fmt #(.LEN_W(LEN_W)) u_fmt (
    .rem_i(rem_q), .eof_i(eof_q), .keep_o(keep), .fin_o(fin), .last_o(last)
  );

  assign rd_req_valid_o = (st_q == S_DRD) || (st_q == S_ARD) || (st_q == S_BRD);
  assign wr_valid_o     = (st_q == S_WB);
  assign wr_addr_o      = cur_q + ADDR_W'(WB_OFS);
  assign wr_data_o      = 32'h8000_0000;
  assign ctl_valid_o    = (st_q == S_AOUT);
  assign ctl_data_o     = hold_q;
  assign ctl_last_o     = ctl_valid_o && (idx_q == IDX_W'(APP_WORDS - 1));
  assign dat_valid_o    = (st_q == S_BOUT);
  assign dat_data_o     = hold_q;
  assign dat_keep_o     = keep;
  assign dat_last_o     = dat_valid_o & last;
  assign cur_ptr_o      = cur_o_q;
  assign cur_upd_o      = upd_q;
  assign halted_o       = halt_q;
  assign idle_set_o     = idle_q;
  assign cmpl_o         = cmpl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      idx_q   <= '0;
      cur_q   <= '0;
      tail_q  <= '0;
      nxt_q   <= '0;
      baddr_q <= '0;
      cur_o_q <= '0;
      len_q   <= '0;
      rem_q   <= '0;
      sof_q   <= 1'b0;
      eof_q   <= 1'b0;
      done_q  <= 1'b0;
      hold_q  <= '0;
      halt_q  <= 1'b0;
      idle_q  <= 1'b0;
      cmpl_q  <= 1'b0;
      upd_q   <= 1'b0;
    end else begin
      halt_q <= 1'b0;
      idle_q <= 1'b0;
      cmpl_q <= 1'b0;
      upd_q  <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start) begin
          cur_q  <= cur_ptr_i;
          tail_q <= tail_ptr_i;
          idx_q  <= '0;
          st_q   <= S_DRD;
        end
        S_DRD: if (rd_req_ready_i) st_q <= S_DWT;
        S_DWT: if (rd_rsp_valid_i) begin
          unique case (idx_q)
            IDX_W'(NEXT_IDX): nxt_q   <= rd_rsp_data_i[ADDR_W-1:0];
            IDX_W'(BUF_IDX):  baddr_q <= rd_rsp_data_i[ADDR_W-1:0];
            IDX_W'(CTRL_IDX): begin
              len_q <= rd_rsp_data_i[LEN_W-1:0];
              sof_q <= rd_rsp_data_i[SOF_BIT];
              eof_q <= rd_rsp_data_i[EOF_BIT];
            end
            IDX_W'(STAT_IDX): done_q <= rd_rsp_data_i[DONE_BIT];
            default: ;
          endcase
          if (idx_q == IDX_W'(DESC_WORDS - 1)) st_q <= S_CHK;
          else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= S_DRD;
          end
        end
        S_CHK: begin
          idx_q <= '0;
          rem_q <= len_q;
          if (done_q) begin
            halt_q <= 1'b1;
            st_q   <= S_IDLE;
          end else if (sof_q) st_q <= S_ARD;
          else if (len_q == '0) st_q <= S_WB;
          else st_q <= S_BRD;
        end
        S_ARD: if (rd_req_ready_i) st_q <= S_AWT;
        S_AWT: if (rd_rsp_valid_i) begin
          hold_q <= rd_rsp_data_i;
          st_q   <= S_AOUT;
        end
        S_AOUT: if (ctl_ready_i) begin
          if (idx_q == IDX_W'(APP_WORDS - 1)) begin
            idx_q <= '0;
            st_q  <= (rem_q == '0) ? S_WB : S_BRD;
          end else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= S_ARD;
          end
        end
        S_BRD: if (rd_req_ready_i) st_q <= S_BWT;
        S_BWT: if (rd_rsp_valid_i) begin
          hold_q <= rd_rsp_data_i;
          st_q   <= S_BOUT;
        end
        S_BOUT: if (dat_ready_i) begin
          baddr_q <= baddr_q + ADDR_W'(BYTES);
          if (fin) begin
            rem_q <= '0;
            st_q  <= S_WB;
          end else begin
            rem_q <= rem_q - LEN_W'(BYTES);
            st_q  <= S_BRD;
          end
        end
        S_WB: if (wr_ready_i) begin
          cmpl_q <= eof_q;
          st_q   <= S_ADV;
        end
        S_ADV: begin
          cur_o_q <= nxt_q;
          upd_q   <= 1'b1;
          cur_q   <= nxt_q;
          idx_q   <= '0;
          if (cur_q == tail_q) begin
            idle_q <= 1'b1;
            st_q   <= S_IDLE;
          end else st_q <= S_DRD;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  a_r8_beat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_valid_o && !dat_ready_i |=> dat_valid_o && $stable(dat_data_o)
      && $stable(dat_keep_o) && $stable(dat_last_o));
  a_r8_no_read_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_valid_o && !dat_ready_i |-> !rd_req_valid_o);
  a_r4_ctl_data_apart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_valid_o |-> !dat_valid_o);
  a_r7_last_needs_eof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_valid_o && dat_last_o |-> eof_q);
  a_r3_halt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !dat_valid_o && !wr_valid_o && !ctl_valid_o);
  a_r11_idle_with_upd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_set_o |-> cur_upd_o);
  a_r10_cmpl_after_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_o |-> $past(wr_valid_o && wr_ready_i));
endmodule

// File: tb/sgw_walker_test.sv
module sgw_walker_test;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic        run_i = 1'b0, idle_i = 1'b0, tail_wr_i = 1'b0;
  logic [31:0] cur_ptr_i = '0, tail_ptr_i = '0;
  logic [31:0] cur_ptr_o;
  logic        cur_upd_o, halted_o, idle_set_o, cmpl_o;
  logic        rd_req_valid_o, rd_req_ready_i = 1'b1;
  logic [31:0] rd_addr_o;
  logic        rd_rsp_valid_i = 1'b0;
  logic [31:0] rd_rsp_data_i = '0;
  logic        wr_valid_o, wr_ready_i = 1'b1;
  logic [31:0] wr_addr_o, wr_data_o;
  logic        ctl_valid_o, ctl_ready_i = 1'b1, ctl_last_o;
  logic [31:0] ctl_data_o;
  logic        dat_valid_o, dat_ready_i = 1'b1, dat_last_o;
  logic [31:0] dat_data_o;
  logic [3:0]  dat_keep_o;

  sgw_walker uut (.*);

  int n_chk = 0, n_bad = 0;
  logic [31:0] mem [0:255];
  logic [31:0] b_data [0:63];
  logic [3:0]  b_keep [0:63];
  logic        b_last [0:63];
  logic [31:0] c_data [0:15];
  logic        c_last [0:15];
  logic [31:0] w_addr [0:7];
  logic [31:0] w_data [0:7];
  int nb, nc, nw, nrd, n_cmpl, n_idle, n_halt, n_upd;
  logic [31:0] last_cur;
  logic        pend = 1'b0;
  logic [31:0] pend_addr = '0;
  logic [7:0]  lfsr = 8'h5A;

  function automatic logic [31:0] buf_word(input logic [31:0] a);
    return {a[15:0] ^ 16'hA5C3, a[15:0]};
  endfunction

  function automatic logic [31:0] rd_word(input logic [31:0] a);
    if (a < 32'h400) return mem[a[9:2]];
    return buf_word(a);
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk_i);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      dat_ready_i = lfsr[0] | lfsr[1];
      ctl_ready_i = lfsr[2] | lfsr[3];
      rd_rsp_valid_i = pend;
      rd_rsp_data_i  = pend ? rd_word(pend_addr) : 32'h0;
      pend = rd_req_valid_o && rd_req_ready_i;
      pend_addr = rd_addr_o;
      if (pend) nrd++;
      if (dat_valid_o && dat_ready_i && nb < 64) begin
        b_data[nb] = dat_data_o; b_keep[nb] = dat_keep_o; b_last[nb] = dat_last_o; nb++;
      end
      if (ctl_valid_o && ctl_ready_i && nc < 16) begin
        c_data[nc] = ctl_data_o; c_last[nc] = ctl_last_o; nc++;
      end
      if (wr_valid_o && wr_ready_i && nw < 8) begin
        w_addr[nw] = wr_addr_o; w_data[nw] = wr_data_o; nw++;
        if (wr_addr_o < 32'h400) mem[wr_addr_o[9:2]] = wr_data_o;
      end
      if (cmpl_o) n_cmpl++;
      if (idle_set_o) n_idle++;
      if (halted_o) n_halt++;
      if (cur_upd_o) begin n_upd++; last_cur = cur_ptr_o; end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic put_desc(input logic [31:0] base, input logic [31:0] nxt, input logic [31:0] bufa,
                          input logic [31:0] ctrl, input logic [31:0] stat);
    mem[base[9:2]]     = nxt;
    mem[base[9:2] + 1] = 32'h0;
    mem[base[9:2] + 2] = bufa;
    mem[base[9:2] + 3] = 32'h0;
    mem[base[9:2] + 4] = 32'hDEAD_BEEF;
    mem[base[9:2] + 5] = 32'hFFFF_FFFF;
    mem[base[9:2] + 6] = ctrl;
    mem[base[9:2] + 7] = stat;
    for (int k = 0; k < 5; k++) mem[base[9:2] + 8 + k] = {base[15:0], 16'h00A0 + 16'(k)};
  endtask

  task automatic clear_cap();
    nb = 0; nc = 0; nw = 0; nrd = 0; n_cmpl = 0; n_idle = 0; n_halt = 0; n_upd = 0;
    last_cur = 32'hFFFF_FFFF;
  endtask

  task automatic walk(input logic [31:0] cur, input logic [31:0] tail);
    int t;
    @(negedge clk_i);
    clear_cap();
    cur_ptr_i = cur; tail_ptr_i = tail; tail_wr_i = 1'b1;
    @(negedge clk_i);
    tail_wr_i = 1'b0;
    t = 0;
    while ((n_idle + n_halt) == 0 && t < 3000) begin @(negedge clk_i); t++; end
    chk(t < 3000, "R11 walk ends", t, 0);
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    clear_cap();
    run_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(!rd_req_valid_o && !dat_valid_o && !ctl_valid_o && !wr_valid_o && !cur_upd_o
        && !halted_o && !idle_set_o && !cmpl_o && cur_ptr_o == 0, "R1 reset state", {28'h0, rd_req_valid_o, dat_valid_o, ctl_valid_o, wr_valid_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R1: trigger ignored when not running, or when idle
    put_desc(32'h100, 32'h200, 32'h1000, 32'h0C00_0004, 32'h0);
    run_i = 1'b0;
    @(negedge clk_i); clear_cap(); cur_ptr_i = 32'h100; tail_ptr_i = 32'h100; tail_wr_i = 1'b1;
    @(negedge clk_i); tail_wr_i = 1'b0; repeat (40) @(negedge clk_i);
    chk(nrd == 0 && nb == 0 && n_idle == 0, "R1 run low ignored", nrd, 0);
    run_i = 1'b1; idle_i = 1'b1;
    @(negedge clk_i); clear_cap(); tail_wr_i = 1'b1;
    @(negedge clk_i); tail_wr_i = 1'b0; repeat (40) @(negedge clk_i);
    chk(nrd == 0 && nb == 0 && n_idle == 0, "R1 idle high ignored", nrd, 0);
    idle_i = 1'b0;

    // single-descriptor sweep over length and frame flags
    for (int fl = 0; fl < 4; fl++) begin
      for (int len = 0; len <= 12; len++) begin
        logic sof, eof;
        int nbeat;
        sof = fl[0]; eof = fl[1];
        nbeat = (len + 3) / 4;
        put_desc(32'h100, 32'h200, 32'h1000 + 32'(len) * 32'h100,
                 {4'h0, sof, eof, 3'b0, 23'(len)}, 32'h0);
        walk(32'h100, 32'h100);
        chk(nc == (sof ? 5 : 0), "R4 app word count", nc, sof ? 5 : 0);
        if (sof) for (int k = 0; k < 5; k++)
          chk(c_data[k] == {16'h0100, 16'h00A0 + 16'(k)} && c_last[k] == (k == 4),
              "R4 app word", c_data[k], {16'h0100, 16'h00A0 + 16'(k)});
        chk(nb == nbeat, "R5 beat count", nb, nbeat);
        for (int i = 0; i < nbeat && i < nb; i++) begin
          logic [3:0] ek;
          ek = (i == nbeat - 1 && (len % 4) != 0) ? 4'((1 << (len % 4)) - 1) : 4'hF;
          chk(b_data[i] == buf_word(32'h1000 + 32'(len) * 32'h100 + 32'(i) * 4), "R5 beat data",
              b_data[i], buf_word(32'h1000 + 32'(len) * 32'h100 + 32'(i) * 4));
          chk(b_keep[i] == ek, "R6 keep", b_keep[i], ek);
          chk(b_last[i] == (eof && i == nbeat - 1), "R7 last", b_last[i], eof && i == nbeat - 1);
        end
        chk(nw == 1 && w_addr[0] == 32'h11C && w_data[0] == 32'h8000_0000, "R9 writeback", w_data[0], 32'h8000_0000);
        chk(n_cmpl == (eof ? 1 : 0), "R10 completion", n_cmpl, eof ? 1 : 0);
        chk(n_upd == 1 && last_cur == 32'h200 && n_idle == 1, "R11 advance", last_cur, 32'h200);
        chk(n_halt == 0, "R3 no halt", n_halt, 0);
      end
    end

    // R2 / R11: three-descriptor chain, frame spans all three
    put_desc(32'h000, 32'h040, 32'h2000, 32'h0800_0005, 32'h0);
    put_desc(32'h040, 32'h080, 32'h3000, 32'h0000_0008, 32'h0);
    put_desc(32'h080, 32'h0C0, 32'h4000, 32'h0400_0003, 32'h0);
    walk(32'h000, 32'h080);
    chk(nc == 5 && c_data[0] == 32'h0000_00A0, "R2 app offset", c_data[0], 32'h0000_00A0);
    chk(nb == 5, "R5 chain beats", nb, 5);
    chk(b_data[0] == buf_word(32'h2000) && b_data[2] == buf_word(32'h3000) && b_data[4] == buf_word(32'h4000),
        "R2 buffer address", b_data[2], buf_word(32'h3000));
    chk(b_last[0] == 0 && b_last[1] == 0 && b_last[3] == 0 && b_last[4] == 1, "R7 chain last", {28'h0, b_last[1], b_last[3], b_last[4]}, 1);
    chk(b_keep[1] == 4'h1 && b_keep[3] == 4'hF && b_keep[4] == 4'h7, "R6 chain keep", {b_keep[1], b_keep[3], b_keep[4]}, 12'h1F7);
    chk(nw == 3 && w_addr[1] == 32'h05C && w_addr[2] == 32'h09C, "R9 chain writeback", w_addr[2], 32'h09C);
    chk(n_cmpl == 1, "R10 one completion", n_cmpl, 1);
    chk(n_upd == 3 && last_cur == 32'h0C0 && n_idle == 1, "R11 chain pointer", last_cur, 32'h0C0);

    // R3: rerun meets descriptor already completed
    walk(32'h000, 32'h080);
    chk(n_halt == 1, "R3 halt pulse", n_halt, 1);
    chk(nb == 0 && nc == 0 && nw == 0 && n_upd == 0 && n_idle == 0, "R3 stopped", nb + nc + nw + n_upd + n_idle, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule